// File: doc/BRIEF.md
# Handshaked Serial Byte Link

This block moves single bytes between a host and a power-management microcontroller. The transfer uses a shift register clocked by the peer and two active-low control wires: a request line that the host drives and an acknowledge line that the peer drives. The host side gives one command at a time: either send a byte or receive a byte. The block prepares its shift register, lowers the request line and then follows the peer's shift clock for eight bits. After the last bit it raises the request line again. It then waits, for a bounded time, until the peer lets go of the acknowledge line.

Each command ends with a single-cycle done pulse. After a receive, the captured byte is on the output. Two status flags describe how the command ended. The warning flag is set when the peer had not asserted acknowledge at the moment the last bit shifted. The timeout flag is set when acknowledge did not return high within the bound. The shift clock, the serial input and the acknowledge line come from the peer's clock domain and are synchronised inside the block. The acknowledge bound is counted by a prescaled timer. With the default parameters it is 3200 steps of 10 µs at 125 MHz.

Top module: `hsl_link`

## Requirements
- R1: After reset the request output is high (negated), busy, done, the timeout flag and the warning flag are all low.
- R2: A send command loads the byte first and then drives request low. On each rising edge of the peer shift clock the serial output presents the next bit, most significant bit first, so the peer sees exactly the commanded byte. Request is low only while busy is high.
- R3: A receive command clears the shift register before request goes low, so the serial output stays 0 during the receive. The eight bits sampled on the shift-clock rising edges, most significant bit first, appear on the received-byte output when done pulses.
- R4: After the eighth shift-clock rising edge, request is driven high. Done is not issued while acknowledge is still low and the bound has not expired, and busy stays high during that wait.
- R5: Done is a pulse of exactly one clock cycle, issued once per accepted command, and request is high whenever done is high.
- R6: If acknowledge stays low after request is negated, the command ends with done and the timeout flag set. This happens no sooner than PRESCALE × ACK_TIMEOUT_TICKS clock cycles after request went high. An acknowledge release within the bound ends the command without the timeout flag.
- R7: If acknowledge is high (not asserted) when the last bit has shifted, the warning flag is set and the command still completes normally.
- R8: A start request made while busy is ignored. The current transfer is unchanged and no further command follows it.
- R9: The timeout and warning flags keep their values while idle and are cleared when the next command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command strobe, taken only when idle |
| dir_tx_i | input | 1 | 1 = send tx_byte_i, 0 = receive a byte |
| tx_byte_i | input | DATA_W | Byte to send |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_byte_o | output | DATA_W | Last received byte |
| timeout_err_o | output | 1 | Acknowledge not released within the bound |
| ack_warn_o | output | 1 | Acknowledge not asserted at shift completion |
| req_n_o | output | 1 | Active-low request to peer |
| ack_n_i | input | 1 | Active-low acknowledge from peer |
| sclk_i | input | 1 | Shift clock from peer |
| sdata_i | input | 1 | Serial data from peer |
| sdata_o | output | 1 | Serial data to peer |

## Verification
The assertions assume three things about the peer. It produces exactly eight shift-clock rising edges while request is low. It holds each serial input bit stable across the synchroniser delay around its rising edge. Each clock phase lasts longer than the synchroniser, so no edge is lost. The bench's peer model keeps every shift-clock phase at four block cycles and changes serial data only on the falling phase. It never toggles the shift clock while request is high. The start strobe is driven for exactly one cycle, except in the deliberate test where a second strobe is issued during a transfer.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_SHIFT = 3'd2,
      ST_CLOSE = 3'd3,
      ST_WAIT  = 3'd4
   } link_state_e;

endpackage

// File: rtl/hsl_sync.sv
module hsl_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hsl_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/hsl_shifter.sv
module hsl_shifter #(
   parameter int DATA_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              load_tx_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   input  logic              shift_i,
   input  logic              ser_in_i,
   output logic              ser_out_o,
   output logic [DATA_W-1:0] par_o,
   output logic              last_o
);

   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("hsl_shifter: DATA_W must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] sh_next;
   logic [CNT_W-1:0]  cnt_q;

   generate
      if (MSB_FIRST) begin : g_msb
         assign sh_next   = {sh_q[DATA_W-2:0], ser_in_i};
         assign ser_out_o = sh_q[DATA_W-1];
      end else begin : g_lsb
         assign sh_next   = {ser_in_i, sh_q[DATA_W-1:1]};
         assign ser_out_o = sh_q[0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (load_i) begin
         sh_q  <= load_tx_i ? tx_byte_i : '0;
         cnt_q <= '0;
      end else if (shift_i) begin
         sh_q  <= sh_next;
         cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   assign par_o  = sh_q;
   assign last_o = (cnt_q == CNT_LAST);

   AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i && shift_i)); // R8

endmodule

// File: rtl/hsl_ack_timer.sv
module hsl_ack_timer #(
   parameter int PRESCALE = 1250,
   parameter int LIMIT    = 3200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);

   localparam int TK_W = $clog2(LIMIT + 1);
   localparam logic [TK_W-1:0] TK_LIMIT = TK_W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("hsl_ack_timer: LIMIT must be at least 1");
      end
      if (PRESCALE < 1) begin : g_bad_pre
         $error("hsl_ack_timer: PRESCALE must be at least 1");
      end
   endgenerate

   logic            tick;
   logic [TK_W-1:0] tc_q;

   generate
      if (PRESCALE > 1) begin : g_pre
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] pc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               pc_q <= '0;
            else if (!run_i)          pc_q <= '0;
            else if (pc_q == PS_LAST) pc_q <= '0;
            else                      pc_q <= pc_q + 1'b1;
         end
         assign tick = run_i && (pc_q == PS_LAST);
      end else begin : g_nopre
         assign tick = run_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  tc_q <= '0;
      else if (!run_i)             tc_q <= '0;
      else if (tick && !expired_o) tc_q <= tc_q + 1'b1;
   end

   assign expired_o = (tc_q == TK_LIMIT);

   AST_TIMER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !expired_o); // R6

endmodule

// File: rtl/hsl_link.sv
module hsl_link #(
   parameter int DATA_W            = 8,
   parameter int SYNC_STAGES       = 2,
   parameter bit MSB_FIRST         = 1'b1,
   parameter int PRESCALE          = 1250,
   parameter int ACK_TIMEOUT_TICKS = 3200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              dir_tx_i,
   input  logic [DATA_W-1:0] tx_byte_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DATA_W-1:0] rx_byte_o,
   output logic              timeout_err_o,
   output logic              ack_warn_o,
   output logic              req_n_o,
   input  logic              ack_n_i,
   input  logic              sclk_i,
   input  logic              sdata_i,
   output logic              sdata_o
);
   import hsl_pkg::*;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("hsl_link: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("hsl_link: SYNC_STAGES must be at least 2");
      end
   endgenerate

   link_state_e       st_q;
   logic              dir_tx_q;
   logic              req_n_q;
   logic              done_q;
   logic              err_q;
   logic              warn_q;
   logic [DATA_W-1:0] rx_q;

   logic sclk_s, sclk_prev_q, ack_s, sdat_s;
   logic accept, shift_en, sh_last, expired;
   logic [DATA_W-1:0] sh_par;

   hsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
      .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
   hsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdat (
      .clk(clk), .rst_n(rst_n), .d_i(sdata_i), .q_o(sdat_s));
   hsl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ack (
      .clk(clk), .rst_n(rst_n), .d_i(ack_n_i), .q_o(ack_s));

   assign accept   = (st_q == ST_IDLE) && start_i;
   assign shift_en = (st_q == ST_SHIFT) && sclk_s && !sclk_prev_q;

   hsl_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .load_i(accept), .load_tx_i(dir_tx_i), .tx_byte_i(tx_byte_i),
      .shift_i(shift_en), .ser_in_i(sdat_s),
      .ser_out_o(sdata_o), .par_o(sh_par), .last_o(sh_last));

   hsl_ack_timer #(.PRESCALE(PRESCALE), .LIMIT(ACK_TIMEOUT_TICKS)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_i(st_q == ST_WAIT), .expired_o(expired));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         dir_tx_q    <= 1'b0;
         req_n_q     <= 1'b1;
         done_q      <= 1'b0;
         err_q       <= 1'b0;
         warn_q      <= 1'b0;
         rx_q        <= '0;
         sclk_prev_q <= 1'b0;
      end else begin
         done_q      <= 1'b0;
         sclk_prev_q <= sclk_s;
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  dir_tx_q <= dir_tx_i;
                  err_q    <= 1'b0;
                  warn_q   <= 1'b0;
                  st_q     <= ST_SETUP;
               end
            end
            ST_SETUP: begin
               req_n_q <= 1'b0;
               st_q    <= ST_SHIFT;
            end
            ST_SHIFT: begin
               if (shift_en && sh_last) st_q <= ST_CLOSE;
            end
            ST_CLOSE: begin
               if (!dir_tx_q) rx_q <= sh_par;
               warn_q  <= ack_s;
               req_n_q <= 1'b1;
               st_q    <= ST_WAIT;
            end
            ST_WAIT: begin
               if (ack_s) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else if (expired) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o        = (st_q != ST_IDLE);
   assign done_o        = done_q;
   assign rx_byte_o     = rx_q;
   assign timeout_err_o = err_q;
   assign ack_warn_o    = warn_q;
   assign req_n_o       = req_n_q;

   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !req_n_o |-> busy_o); // R2
   AST_REQ_HIGH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> req_n_o); // R4
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R5
   AST_TIMEOUT_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT && expired && !ack_s) |=> (timeout_err_o && done_o)); // R6
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> $stable(dir_tx_q)); // R8
   AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> ($stable(timeout_err_o) && $stable(ack_warn_o))); // R9

endmodule

// File: tb/tb_hsl_link.sv
module tb_hsl_link;

   localparam int PRE = 4;
   localparam int TMO = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0, dir_tx_i = 1'b0;
   logic [7:0] tx_byte_i = '0;
   logic busy_o, done_o, timeout_err_o, ack_warn_o, req_n_o, sdata_o;
   logic [7:0] rx_byte_o;
   logic ack_n_i = 1'b1, sclk_i = 1'b0, sdata_i = 1'b0;

   int checks = 0, fails = 0;
   int cyc = 0, done_cnt = 0;
   int t_req_hi = 0, t_done = 0;
   logic [7:0] seen, got_rx;
   logic got_err, got_warn;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (done_o === 1'b1) done_cnt <= done_cnt + 1;

   hsl_link #(.DATA_W(8), .SYNC_STAGES(2), .MSB_FIRST(1'b1),
              .PRESCALE(PRE), .ACK_TIMEOUT_TICKS(TMO)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_tx_i(dir_tx_i),
      .tx_byte_i(tx_byte_i), .busy_o(busy_o), .done_o(done_o),
      .rx_byte_o(rx_byte_o), .timeout_err_o(timeout_err_o),
      .ack_warn_o(ack_warn_o), .req_n_o(req_n_o), .ack_n_i(ack_n_i),
      .sclk_i(sclk_i), .sdata_i(sdata_i), .sdata_o(sdata_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic dir, input logic [7:0] b);
      @(negedge clk);
      start_i = 1'b1; dir_tx_i = dir; tx_byte_i = b;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (done_o !== 1'b1 && n < 3000) begin @(negedge clk); n++; end
      t_done = cyc;
      got_rx = rx_byte_o; got_err = timeout_err_o; got_warn = ack_warn_o;
      chk("R5 done seen", {31'd0, done_o}, 32'd1);
      @(negedge clk);
      chk("R5 done one cycle", {31'd0, done_o}, 32'd0);
   endtask

   task automatic peer(input logic [7:0] pout, input bit do_ack,
                       input bit release_ack, input int rel_delay);
      int n = 0;
      bit ok = 1'b1;
      seen = '0;
      while (req_n_o !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
      if (do_ack) ack_n_i = 1'b0;
      repeat (3) @(negedge clk);
      for (int i = 7; i >= 0; i--) begin
         sdata_i = pout[i];
         repeat (4) @(negedge clk);
         sclk_i = 1'b1;
         seen[i] = sdata_o;
         repeat (4) @(negedge clk);
         sclk_i = 1'b0;
      end
      n = 0;
      while (req_n_o !== 1'b1 && n < 200) begin @(negedge clk); n++; end
      t_req_hi = cyc;
      if (release_ack) begin
         for (int k = 0; k < rel_delay; k++) begin
            if (busy_o !== 1'b1 || done_o !== 1'b0) ok = 1'b0;
            @(negedge clk);
         end
         ack_n_i = 1'b1;
         if (rel_delay > 0) chk("R4 busy held while ack low", {31'd0, ok}, 32'd1);
      end
   endtask

   task automatic t_reset();
      chk("R1 req_n", {31'd0, req_n_o}, 32'd1);
      chk("R1 busy", {31'd0, busy_o}, 32'd0);
      chk("R1 done", {31'd0, done_o}, 32'd0);
      chk("R1 flags", {30'd0, timeout_err_o, ack_warn_o}, 32'd0);
   endtask

   task automatic t_send(input logic [7:0] b, input logic [7:0] pin);
      fork
         begin issue(1'b1, b); wait_done(); end
         peer(pin, 1'b1, 1'b1, 2);
      join
      chk("R2 peer saw byte", {24'd0, seen}, {24'd0, b});
      chk("R4 clean end", {30'd0, got_err, got_warn}, 32'd0);
   endtask

   task automatic t_recv(input logic [7:0] pout);
      fork
         begin issue(1'b0, 8'hFF); wait_done(); end
         peer(pout, 1'b1, 1'b1, 1);
      join
      chk("R3 rx byte", {24'd0, got_rx}, {24'd0, pout});
      chk("R3 sdata_o held 0", {24'd0, seen}, 32'd0);
   endtask

   task automatic t_slow_ack();
      fork
         begin issue(1'b1, 8'h66); wait_done(); end
         peer(8'h00, 1'b1, 1'b1, 12);
      join
      chk("R6 no timeout within bound", {31'd0, got_err}, 32'd0);
      chk("R4 done after release", {31'd0, (t_done - t_req_hi) >= 12}, 32'd1);
   endtask

   task automatic t_timeout();
      fork
         begin issue(1'b1, 8'h5A); wait_done(); end
         peer(8'h00, 1'b1, 1'b0, 0);
      join
      chk("R6 timeout flag", {31'd0, got_err}, 32'd1);
      chk("R6 bound length", {31'd0, (t_done - t_req_hi) >= PRE * TMO}, 32'd1);
      ack_n_i = 1'b1;
      repeat (10) @(negedge clk);
      chk("R9 flag held idle", {31'd0, timeout_err_o}, 32'd1);
      fork
         begin
            issue(1'b1, 8'h11);
            chk("R9 flag cleared on accept", {31'd0, timeout_err_o}, 32'd0);
            wait_done();
         end
         peer(8'h00, 1'b1, 1'b1, 1);
      join
   endtask

   task automatic t_warn();
      fork
         begin issue(1'b1, 8'h96); wait_done(); end
         peer(8'h00, 1'b0, 1'b0, 0);
      join
      chk("R7 warn flag", {31'd0, got_warn}, 32'd1);
      chk("R7 completes without timeout", {31'd0, got_err}, 32'd0);
      chk("R7 byte still sent", {24'd0, seen}, 32'h96);
   endtask

   task automatic t_busy_refuse();
      int d0;
      d0 = done_cnt;
      fork
         begin
            issue(1'b1, 8'hC3);
            repeat (20) @(negedge clk);
            issue(1'b0, 8'h00);
            wait_done();
         end
         peer(8'h00, 1'b1, 1'b1, 1);
      join
      chk("R8 original byte sent", {24'd0, seen}, 32'hC3);
      repeat (30) @(negedge clk);
      chk("R8 no queued command", {31'd0, busy_o}, 32'd0);
      chk("R8 single done", done_cnt - d0, 32'd1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_send(8'hA5, 8'hFF);
      t_send(8'h81, 8'h00);
      t_recv(8'h5A);
      t_send(8'h3C, 8'hFF);
      t_recv(8'hC6);
      t_slow_ack();
      t_timeout();
      t_warn();
      t_busy_refuse();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule